// File: doc/BRIEF.md
# Serial Shift Register with Strobed Parallel Store

The block takes a serial bit stream and shifts it into a chain of stages, one place per rising clock edge. Each stage has its own storage latch. The latches are transparent while a strobe input is high and hold their contents while it is low. While the strobe stays low the chain can therefore be refilled, and the parallel word does not change.

The stored word is presented as a value bus plus a per-bit drive-enable bus. A surrounding pad ring or bus wrapper turns each value and drive pair into a real three-state line. Output enable controls only the drive bits. The last stage leaves the block on two serial taps: one switches on the rising edge and one re-times that bit onto the following falling edge.

Either tap can feed the data input of the next instance, so several instances form one long chain that shares clock and strobe. The late tap suits a clock with slow edges.

Top module: `ssr_shift_store`

## Requirements
- R1: A synchronous reset (rst_i high at a rising edge) clears every shift stage and ser_o to 0. ser_late_o is cleared at the next falling edge while reset is high. The storage latches are not cleared by reset; they are cleared only by passing the zeroed chain through while the strobe is high.
- R2: At each rising edge with reset low, din_i enters stage 0 and stage n takes the old value of stage n-1. Stage n appears on par_val_o bit n.
- R3: While strobe_i is high, par_val_o follows the shift stages. This includes a strobe pulse that starts and ends between two clock edges.
- R4: While strobe_i is low, par_val_o holds the value it had when the strobe fell. Rising edges and reset do not change it.
- R5: par_drv_o is all ones when oe_i is high and all zeros when oe_i is low. All zeros means the outputs are high-impedance. par_val_o keeps the stored word in both cases.
- R6: At each rising edge, ser_o takes the old value of stage STAGES-2. That is the same bit that moves into the last stage, so ser_o always equals the last stage.
- R7: At each falling edge, ser_late_o takes the value of ser_o and holds it through the next high phase of the clock.
- R8: oe_i has no effect on ser_o or ser_late_o; both keep shifting while the parallel outputs are not driven.
- R9: When ser_o or ser_late_o feeds the din_i of a second instance on the same clock and strobe, the two instances act as one 2*STAGES chain. After 2*STAGES clocks and a strobe, the first instance holds the word shifted in last and the second holds the word shifted in first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the chain shifts on the rising edge, the late tap updates on the falling edge |
| rst_i | input | 1 | Synchronous active-high reset of the chain and both serial taps |
| din_i | input | 1 | Serial data into stage 0 |
| strobe_i | input | 1 | High: storage latches are transparent; low: they hold |
| oe_i | input | 1 | High: drive the parallel outputs; low: high-impedance |
| par_val_o | output | STAGES | Stored word; bit n belongs to stage n |
| par_drv_o | output | STAGES | Per-bit drive enable for the three-state parallel outputs |
| ser_o | output | 1 | Last stage, updated on the rising edge |
| ser_late_o | output | 1 | Last stage re-timed onto the falling edge |

## Verification
The bench builds three instances with the default of eight stages. The first instance feeds a second through its rising-edge tap and a third through its falling-edge tap. With eight stages, a 16-clock run makes both cascade paths produce two complete known bytes. Each byte of the stimulus table fills a whole stage chain, so every transparent, holding and undriven combination shows a full word at the outputs. A strobe pulse placed entirely between clock edges, followed by a reset in mid-run, covers the latch behaviour that a clocked store would miss.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    localparam int unsigned SSR_DEF_STAGES = 8;

    typedef struct packed {
        logic store;
        logic drive;
    } ssr_ctrl_t;

endpackage

// File: rtl/ssr_shift_chain.sv
module ssr_shift_chain #(
    parameter int unsigned STAGES = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              din_i,
    output logic [STAGES-1:0] stage_o,
    output logic              tail_o
);

    localparam int unsigned TOP = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] stage;
    } chain_state_t;

    chain_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (rst_i) begin
            state_d.stage = '0;
        end else begin
            state_d.stage = {state_q.stage[TOP-1:0], din_i};
        end
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    assign stage_o = state_q.stage;
    assign tail_o  = state_q.stage[TOP];

    // R1: the first edge after reset shows a cleared chain
    p_reset_clears_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> state_q.stage == '0);

    // R2: one place per rising edge, din into stage 0
    p_shift_one_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(!rst_i) |-> state_q.stage == {$past(state_q.stage[TOP-1:0]), $past(din_i)});

endmodule

// File: rtl/ssr_store_bank.sv
module ssr_store_bank #(
    parameter int unsigned STAGES = 8
) (
    input  logic              store_i,
    input  logic [STAGES-1:0] stage_i,
    output logic [STAGES-1:0] held_o
);

    logic [STAGES-1:0] held_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_cell
        always_latch begin
            if (store_i) begin
                held_q[g] <= stage_i[g];
            end
        end
    end

    assign held_o = held_q;

endmodule

// File: rtl/ssr_late_tap.sv
module ssr_late_tap (
    input  logic clk_i,
    input  logic rst_i,
    input  logic bit_i,
    output logic late_o
);

    logic late_d, late_q;

    always_comb begin
        late_d = rst_i ? 1'b0 : bit_i;
    end

    always_ff @(negedge clk_i) begin
        late_q <= late_d;
    end

    assign late_o = late_q;

endmodule

// File: rtl/ssr_shift_store.sv
module ssr_shift_store
    import ssr_pkg::*;
#(
    parameter int unsigned STAGES = SSR_DEF_STAGES
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              din_i,
    input  logic              strobe_i,
    input  logic              oe_i,
    output logic [STAGES-1:0] par_val_o,
    output logic [STAGES-1:0] par_drv_o,
    output logic              ser_o,
    output logic              ser_late_o
);

    localparam int unsigned PRE = STAGES - 2;

    ssr_ctrl_t         ctrl;
    logic [STAGES-1:0] stage_q;
    logic [STAGES-1:0] held;
    logic              tail;

    assign ctrl = '{store: strobe_i, drive: oe_i};

    ssr_shift_chain #(.STAGES(STAGES)) u_chain (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .din_i   (din_i),
        .stage_o (stage_q),
        .tail_o  (tail)
    );

    ssr_store_bank #(.STAGES(STAGES)) u_store (
        .store_i (ctrl.store),
        .stage_i (stage_q),
        .held_o  (held)
    );

    ssr_late_tap u_late (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .bit_i  (tail),
        .late_o (ser_late_o)
    );

    for (genvar g = 0; g < STAGES; g++) begin : g_pad
        assign par_val_o[g] = held[g];
        assign par_drv_o[g] = ctrl.drive;
    end

    assign ser_o = tail;

    // R3: a transparent store shows the chain at the parallel outputs
    p_transparent_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        strobe_i |-> par_val_o == stage_q);

    // R6: the early tap takes the next-to-last stage at each rising edge
    p_early_tap_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(!rst_i) |-> ser_o == $past(stage_q[PRE]));

    // R7: the late tap repeats the early tap one falling edge later
    p_late_tap_r7: assert property (@(negedge clk_i) disable iff (rst_i)
        !rst_i |=> ser_late_o == $past(ser_o));

endmodule

// File: tb/ssr_shift_store_bench.sv
module ssr_shift_store_bench;

    localparam int unsigned N = 8;

    // byte, strobe, output enable
    localparam logic [9:0] VEC [6] = '{
        {8'hA5, 2'b11}, {8'h3C, 2'b01}, {8'hF0, 2'b10},
        {8'h0F, 2'b00}, {8'h81, 2'b11}, {8'h66, 2'b01}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst = 1'b1, din = 1'b1, strobe = 1'b1, oe = 1'b1;

    logic [N-1:0] par_a, drv_a, par_b, drv_b, par_c, drv_c;
    logic ser_a, late_a, ser_b, late_b, ser_c, late_c;

    ssr_shift_store #(.STAGES(N)) u_ssr_shift_store (
        .clk_i(clk), .rst_i(rst), .din_i(din), .strobe_i(strobe), .oe_i(oe),
        .par_val_o(par_a), .par_drv_o(drv_a), .ser_o(ser_a), .ser_late_o(late_a));

    ssr_shift_store #(.STAGES(N)) u_ssr_shift_store_b (
        .clk_i(clk), .rst_i(rst), .din_i(ser_a), .strobe_i(strobe), .oe_i(oe),
        .par_val_o(par_b), .par_drv_o(drv_b), .ser_o(ser_b), .ser_late_o(late_b));

    ssr_shift_store #(.STAGES(N)) u_ssr_shift_store_c (
        .clk_i(clk), .rst_i(rst), .din_i(late_a), .strobe_i(strobe), .oe_i(oe),
        .par_val_o(par_c), .par_drv_o(drv_c), .ser_o(ser_c), .ser_late_o(late_c));

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [2*N-1:0] chain;
    logic [N-1:0] st_a, st_b;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // entered at falling edge + 2 ns, leaves at the next falling edge + 2 ns
    task automatic step(input logic d, input logic s, input logic e);
        din = d; strobe = s; oe = e;
        @(posedge clk); #5;
        chain = {chain[2*N-2:0], d};
        if (s) begin
            st_a = chain[N-1:0];
            st_b = chain[2*N-1:N];
        end
        chk(e ? "R6 early tap" : "R8 early tap with outputs off", ser_a, chain[N-1]);
        chk(s ? "R2/R3 stages through store A" : "R4 store A holds", par_a, st_a);
        chk("R9 cascade via early tap", par_b, st_b);
        chk("R9 cascade via late tap", par_c, st_b);
        chk("R9 second instance tail", ser_b, chain[2*N-1]);
        chk("R5 drive enables", drv_a, {N{e}});
        @(negedge clk); #2;
        chk(e ? "R7 late tap" : "R8 late tap with outputs off", late_a, chain[N-1]);
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset with strobe open
        repeat (3) @(posedge clk);
        #5;
        chk("R1 early tap cleared", ser_a, 1'b0);
        chk("R1 chain cleared through store", par_a, 8'h00);
        chk("R1 second instance cleared", par_b, 8'h00);
        @(negedge clk); #2;
        chk("R1 late tap cleared", late_a, 1'b0);
        rst = 1'b0;
        chain = '0; st_a = '0; st_b = '0;

        for (int v = 0; v < 6; v++) begin
            for (int b = N - 1; b >= 0; b--) begin
                step(VEC[v][b+2], VEC[v][1], VEC[v][0]);
            end
            chk("R5 value kept whatever the enable", par_a, st_a);
        end

        // R9: 16 clocks with strobe low, then a strobe pulse between edges
        for (int b = 7; b >= 0; b--) step(8'hC3 >> b, 1'b0, 1'b1);
        for (int b = 7; b >= 0; b--) step(8'h5A >> b, 1'b0, 1'b1);
        #1 strobe = 1'b1;
        #2;
        chk("R9 first instance holds last byte", par_a, 8'h5A);
        chk("R9 early-tap neighbour holds first byte", par_b, 8'hC3);
        chk("R9 late-tap neighbour holds first byte", par_c, 8'hC3);
        chk("R3 pulse between edges", par_a, chain[N-1:0]);
        strobe = 1'b0;
        #2;
        chk("R4 latch keeps pulse value", par_a, 8'h5A);
        st_a = 8'h5A; st_b = 8'hC3;
        step(1'b1, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b0);

        // R1: reset in mid-run leaves the latches alone
        rst = 1'b1; strobe = 1'b0;
        @(posedge clk); #5;
        chk("R1 early tap cleared in run", ser_a, 1'b0);
        chk("R4 store unaffected by reset", par_a, st_a);
        @(negedge clk); #2;
        chk("R1 late tap cleared in run", late_a, 1'b0);
        rst = 1'b0;
        chain = '0;
        step(1'b1, 1'b1, 1'b1);
        chk("R2 single one in stage 0", par_a, 8'h01);

        finish_run();
    end

endmodule